// File: doc/BRIEF.md
# Eight-Line Prioritised Interrupt Controller

The block gathers eight interrupt inputs, turns rising edges into pending requests, filters them through a mask and picks the most urgent one, which it signals to the processor on a single interrupt output. The processor answers with a one-cycle acknowledge strobe. During that strobe the block presents an 8-bit vector built from a programmable base and the winning line number, and at the clock edge that ends the strobe it moves the line from pending to in-service.

Software drives the block through a byte-wide register bus with three ports: a command port, a data port and a trigger-mode port. A command write with bit 4 set starts a short set-up sequence on the data port (vector base, a cascade word that is discarded, and an optional fourth word). Later command writes select what command-port reads return, switch special mask mode on or off, or retire in-service lines. The trigger-mode port marks each line as edge or level sensitive, and this decides whether an acknowledge consumes the request.

Priority is fixed: line 0 is the most urgent. A new line reaches the processor only when every line already in service has a larger number. In special mask mode, in-service lines that are masked do not take part in this comparison.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset, int_req is low, the data port reads 0xFF (all lines masked), the trigger-mode port reads 0x00, the command port reads 0x00, auto end-of-interrupt is on and the set-up sequence is idle.
- R2: A command-port write with bit 4 set clears the pending, in-service and tracked-level state. It masks all lines, turns auto end-of-interrupt on and withdraws an interrupt already raised, so int_req is low in the next cycle. It keeps bit 0 as the flag that a fourth set-up word will follow, and it starts the set-up sequence.
- R3: After a set-up start, the first data-port write loads the vector base and the second is discarded. The sequence then goes idle. In idle, if a fourth word is owed, the next data-port write is taken as that word and its bit 1 selects auto end-of-interrupt (1 = on). Any other idle data-port write loads the mask (1 = line masked), and the data port reads the mask back.
- R4: A command-port write with bit 4 clear and bit 3 set is a mode command. When its bit 1 is 1, bit 0 chooses what the command port reads (1 = in-service register, 0 = pending register). When its bit 6 is 1, bit 5 turns special mask mode on (1) or off (0). Other bits have no effect.
- R5: A command-port write with bits 4 and 3 both clear retires in-service lines according to bits 7:5. With 001 it clears the lowest-numbered in-service bit. With 011 it clears the in-service bit numbered by bits 2:0. With bits 7:6 = 11 it changes nothing. Every other code acts like 001.
- R6: A pending bit is set only when its input goes from low to high. An input held high does not set it again after it has been consumed. An input that is low clears its pending bit one clock later.
- R7: The candidate is the lowest-numbered line that is pending and unmasked. It is raised only if no line is in service or the lowest in-service line number is greater than the candidate. In special mask mode, in-service lines that are masked are left out of this comparison.
- R8: During an acknowledge, ack_vector equals the vector base OR the line number. At the end of the strobe the pending bit is cleared unless the line's trigger-mode bit is 1 (level), and the in-service bit is set unless auto end-of-interrupt is on.
- R9: An acknowledge while the pending register is zero yields the vector base OR 7 and changes no in-service bit.
- R10: int_req stays high from the clock where a candidate is captured until an acknowledge. It is low in the cycle after the acknowledge, and arbitration runs again on the following clock.
- R11: The trigger-mode port is a read/write byte (bit n = 1 makes line n level sensitive). It is cleared only by reset, not by a set-up start.
- R12: bus_sel encodes 0 = command, 1 = data, 2 = trigger mode, 3 = unused (reads 0x00, writes ignored). Reads are combinational on the selected register, and writes take effect at the clock edge where bus_wr is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Port select: 0 command, 1 data, 2 trigger mode |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected port |
| irq_lines | input | 8 | Interrupt inputs, line 0 most urgent |
| int_req | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | One-cycle acknowledge strobe |
| ack_vector | output | 8 | Vector, valid while int_ack is high |

## Verification
The bench builds the block with its default of eight lines. At that width the line number fills the low three bits of the vector, so the spurious code 7 and a vector base with high bits set are both reachable. Every input pattern is driven through a behavioural model that tracks pending, in-service and mask state as plain bytes. That model makes it possible to walk through the nested-priority blocking, the special-mask release, the level-mode re-request followed by the spurious acknowledge, and a set-up restart with a request already raised.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  typedef enum logic [1:0] {
    PORT_CMD  = 2'd0,
    PORT_DATA = 2'd1,
    PORT_TRIG = 2'd2,
    PORT_NONE = 2'd3
  } port_sel_e;

  typedef enum logic [1:0] {
    SETUP_IDLE = 2'd0,
    SETUP_BASE = 2'd1,
    SETUP_CASC = 2'd2
  } setup_st_e;

  // retire-command codes in bits 7:5
  localparam logic [2:0] RETIRE_LOWEST = 3'b001;
  localparam logic [2:0] RETIRE_INDEX  = 3'b011;

endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_in,
  input  logic             clr_all,
  input  logic [LINES-1:0] ack_clr,
  output logic [LINES-1:0] pend_q
);

  logic [LINES-1:0] seen_q;
  logic [LINES-1:0] seen_d;
  logic [LINES-1:0] pend_d;

  for (genvar g = 0; g < LINES; g++) begin : g_cell
    always_comb begin
      seen_d[g] = seen_q[g];
      pend_d[g] = pend_q[g];
      if (!line_in[g]) begin
        seen_d[g] = 1'b0;
        pend_d[g] = 1'b0;
      end else if (!seen_q[g]) begin
        seen_d[g] = 1'b1;
        pend_d[g] = 1'b1;
      end
      if (ack_clr[g]) pend_d[g] = 1'b0;
      if (clr_all) begin
        seen_d[g] = 1'b0;
        pend_d[g] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      pend_q <= '0;
    end else begin
      seen_q <= seen_d;
      pend_q <= pend_d;
    end
  end

  // R6: a pending bit only appears after the input was high
  assert_pend_rise_needs_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(line_in)) == '0));

  // R6: a low input leaves no pending bit behind
  assert_low_input_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(line_in)) == '0));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int LINES = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] pend,
  input  logic [LINES-1:0] insvc,
  input  logic [LINES-1:0] mask,
  input  logic             smm,
  output logic             cand_ok,
  output logic [IDX_W-1:0] cand_idx
);

  logic [LINES-1:0] live;
  logic [LINES-1:0] svc_eff;
  logic             live_any;
  logic             svc_any;
  logic [IDX_W-1:0] svc_idx;

  always_comb begin
    live     = pend & ~mask;
    svc_eff  = smm ? (insvc & ~mask) : insvc;
    live_any = |live;
    svc_any  = |svc_eff;
    cand_idx = '0;
    svc_idx  = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (live[i])    cand_idx = IDX_W'(i);
      if (svc_eff[i]) svc_idx  = IDX_W'(i);
    end
    cand_ok = live_any && (!svc_any || (svc_idx > cand_idx));
  end

endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_ctrl_pkg::*;
#(
  parameter int LINES = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_sel,
  input  logic [LINES-1:0] bus_wdata,
  input  logic [LINES-1:0] pend,
  input  logic             ack_hit,
  input  logic [IDX_W-1:0] ack_idx,
  output logic [LINES-1:0] bus_rdata,
  output logic [LINES-1:0] mask_q,
  output logic [LINES-1:0] base_q,
  output logic [LINES-1:0] trig_q,
  output logic [LINES-1:0] insvc_q,
  output logic             smm_q,
  output logic             setup_start
);

  setup_st_e        st_q, st_d;
  logic             fourth_q, fourth_d;
  logic             autoeoi_q, autoeoi_d;
  logic             rdsvc_q, rdsvc_d;
  logic             smm_d;
  logic [LINES-1:0] mask_d, base_d, trig_d, insvc_d;
  logic             wr_cmd, wr_data, wr_trig;
  port_sel_e        sel;

  always_comb begin
    sel         = port_sel_e'(bus_sel);
    wr_cmd      = bus_wr && (sel == PORT_CMD);
    wr_data     = bus_wr && (sel == PORT_DATA);
    wr_trig     = bus_wr && (sel == PORT_TRIG);
    setup_start = wr_cmd && bus_wdata[4];
  end

  always_comb begin
    st_d      = st_q;
    fourth_d  = fourth_q;
    autoeoi_d = autoeoi_q;
    rdsvc_d   = rdsvc_q;
    smm_d     = smm_q;
    mask_d    = mask_q;
    base_d    = base_q;
    trig_d    = trig_q;
    insvc_d   = insvc_q;

    if (wr_cmd && !bus_wdata[4]) begin
      if (bus_wdata[3]) begin
        if (bus_wdata[1]) rdsvc_d = bus_wdata[0];
        if (bus_wdata[6]) smm_d   = bus_wdata[5];
      end else if (bus_wdata[7:5] == RETIRE_INDEX) begin
        insvc_d[bus_wdata[IDX_W-1:0]] = 1'b0;
      end else if (bus_wdata[7:6] == 2'b11) begin
        insvc_d = insvc_q;
      end else begin
        insvc_d = insvc_q & (insvc_q - LINES'(1));
      end
    end

    if (ack_hit && !autoeoi_q) insvc_d[ack_idx] = 1'b1;

    if (wr_data) begin
      unique case (st_q)
        SETUP_BASE: begin
          base_d = bus_wdata;
          st_d   = SETUP_CASC;
        end
        SETUP_CASC: st_d = SETUP_IDLE;
        default: begin
          if (fourth_q) begin
            autoeoi_d = bus_wdata[1];
            fourth_d  = 1'b0;
          end else begin
            mask_d = bus_wdata;
          end
        end
      endcase
    end

    if (wr_trig) trig_d = bus_wdata;

    if (setup_start) begin
      insvc_d   = '0;
      mask_d    = '1;
      autoeoi_d = 1'b1;
      fourth_d  = bus_wdata[0];
      st_d      = SETUP_BASE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SETUP_IDLE;
      fourth_q  <= 1'b0;
      autoeoi_q <= 1'b1;
      rdsvc_q   <= 1'b0;
      smm_q     <= 1'b0;
      mask_q    <= '1;
      base_q    <= '0;
      trig_q    <= '0;
      insvc_q   <= '0;
    end else begin
      st_q      <= st_d;
      fourth_q  <= fourth_d;
      autoeoi_q <= autoeoi_d;
      rdsvc_q   <= rdsvc_d;
      smm_q     <= smm_d;
      mask_q    <= mask_d;
      base_q    <= base_d;
      trig_q    <= trig_d;
      insvc_q   <= insvc_d;
    end
  end

  always_comb begin
    unique case (sel)
      PORT_CMD:  bus_rdata = rdsvc_q ? insvc_q : pend;
      PORT_DATA: bus_rdata = mask_q;
      PORT_TRIG: bus_rdata = trig_q;
      default:   bus_rdata = '0;
    endcase
  end

  // R2: a set-up start leaves everything masked, nothing in service
  assert_setup_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    setup_start |=> (mask_q == '1) && (insvc_q == '0) && autoeoi_q);

  // R8: with auto end-of-interrupt an acknowledge adds no in-service bit
  assert_autoeoi_no_svc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && autoeoi_q) |=> ((insvc_q & ~$past(insvc_q)) == '0));

  // R11: trigger mode changes only through its own port
  assert_trig_only_by_port_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_trig |=> $stable(trig_q));

endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8 #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_sel,
  input  logic [LINES-1:0] bus_wdata,
  output logic [LINES-1:0] bus_rdata,
  input  logic [LINES-1:0] irq_lines,
  output logic             int_req,
  input  logic             int_ack,
  output logic [LINES-1:0] ack_vector
);

  localparam int IDX_W = $clog2(LINES);
  localparam logic [IDX_W-1:0] IDX_SPUR = IDX_W'(LINES - 1);

  logic [LINES-1:0] pend, insvc, mask, base, trig, ack_clr;
  logic             smm, setup_start, cand_ok, ack_hit;
  logic [IDX_W-1:0] cand_idx, ack_idx;
  logic             raised_q, raised_d;
  logic [IDX_W-1:0] line_q, line_d;

  irq_req_latch #(.LINES(LINES)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (irq_lines),
    .clr_all (setup_start),
    .ack_clr (ack_clr),
    .pend_q  (pend)
  );

  irq_arbiter #(.LINES(LINES)) u_arb (
    .pend     (pend),
    .insvc    (insvc),
    .mask     (mask),
    .smm      (smm),
    .cand_ok  (cand_ok),
    .cand_idx (cand_idx)
  );

  irq_regs #(.LINES(LINES)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_sel     (bus_sel),
    .bus_wdata   (bus_wdata),
    .pend        (pend),
    .ack_hit     (ack_hit),
    .ack_idx     (ack_idx),
    .bus_rdata   (bus_rdata),
    .mask_q      (mask),
    .base_q      (base),
    .trig_q      (trig),
    .insvc_q     (insvc),
    .smm_q       (smm),
    .setup_start (setup_start)
  );

  always_comb begin
    ack_hit    = int_ack && raised_q && (pend != '0);
    ack_idx    = line_q;
    ack_clr    = (ack_hit && !trig[line_q]) ? (LINES'(1) << line_q) : '0;
    ack_vector = base | LINES'(ack_hit ? line_q : IDX_SPUR);
    int_req    = raised_q;

    raised_d = raised_q;
    line_d   = line_q;
    if (setup_start || int_ack) begin
      raised_d = 1'b0;
    end else if (!raised_q && cand_ok) begin
      raised_d = 1'b1;
      line_d   = cand_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raised_q <= 1'b0;
      line_q   <= '0;
    end else begin
      raised_q <= raised_d;
      line_q   <= line_d;
    end
  end

  // R10: a raised request holds until acknowledged or set-up restarts
  assert_req_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && !int_ack && !setup_start) |=> int_req);

  // R10: the cycle after an acknowledge the request is low
  assert_req_drops_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |=> !int_req);

  // R9: an acknowledge with nothing pending leaves in-service untouched
  assert_spurious_keeps_svc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && (pend == '0) && !bus_wr) |=> $stable(insvc));

endmodule

// File: tb/irq_ctrl8_tb_top.sv
module irq_ctrl8_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] irq_lines = 8'h00;
  logic       int_req;
  logic       int_ack = 1'b0;
  logic [7:0] ack_vector;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_ctrl8 dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_sel    (bus_sel),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_lines  (irq_lines),
    .int_req    (int_req),
    .int_ack    (int_ack),
    .ack_vector (ack_vector)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_pend, m_seen, m_svc, m_mask, m_base, m_trig;
  bit m_auto, m_fourth, m_rdsvc, m_smm, m_up;
  int m_line, m_step;
  logic [7:0] n_pend, n_seen, n_svc, n_mask, n_base, n_trig;
  bit n_auto, n_fourth, n_rdsvc, n_smm, n_up;
  int n_line, n_step;

  function automatic int lowest(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] m_read(logic [1:0] s);
    case (s)
      2'd0: return m_rdsvc ? m_svc : m_pend;
      2'd1: return m_mask;
      2'd2: return m_trig;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] m_vec();
    if (m_up && m_pend != 8'h00) return m_base | 8'(m_line);
    return m_base | 8'h07;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_seen = 0; m_svc = 0; m_mask = 8'hFF; m_base = 0; m_trig = 0;
      m_auto = 1; m_fourth = 0; m_rdsvc = 0; m_smm = 0; m_up = 0; m_line = 0; m_step = 0;
    end else begin
      n_pend = m_pend; n_seen = m_seen; n_svc = m_svc; n_mask = m_mask;
      n_base = m_base; n_trig = m_trig; n_auto = m_auto; n_fourth = m_fourth;
      n_rdsvc = m_rdsvc; n_smm = m_smm; n_up = m_up; n_line = m_line; n_step = m_step;
      for (int i = 0; i < 8; i++) begin
        if (!irq_lines[i]) begin n_seen[i] = 0; n_pend[i] = 0; end
        else if (!m_seen[i]) begin n_seen[i] = 1; n_pend[i] = 1; end
      end
      if (!m_up) begin
        int c, s;
        c = lowest(m_pend & ~m_mask);
        s = lowest(m_smm ? (m_svc & ~m_mask) : m_svc);
        if (c >= 0 && (s < 0 || s > c)) begin n_up = 1; n_line = c; end
      end
      if (bus_wr && bus_sel == 2'd0 && !bus_wdata[4]) begin
        if (bus_wdata[3]) begin
          if (bus_wdata[1]) n_rdsvc = bus_wdata[0];
          if (bus_wdata[6]) n_smm = bus_wdata[5];
        end else if (bus_wdata[7:5] == 3'b011) n_svc[bus_wdata[2:0]] = 0;
        else if (bus_wdata[7:6] != 2'b11) begin
          int l;
          l = lowest(m_svc);
          if (l >= 0) n_svc[l] = 0;
        end
      end
      if (int_ack) begin
        n_up = 0;
        if (m_up && m_pend != 0) begin
          if (!m_trig[m_line]) n_pend[m_line] = 0;
          if (!m_auto) n_svc[m_line] = 1;
        end
      end
      if (bus_wr && bus_sel == 2'd1) begin
        if (m_step == 1) begin n_base = bus_wdata; n_step = 2; end
        else if (m_step == 2) n_step = 0;
        else if (m_fourth) begin n_auto = bus_wdata[1]; n_fourth = 0; end
        else n_mask = bus_wdata;
      end
      if (bus_wr && bus_sel == 2'd2) n_trig = bus_wdata;
      if (bus_wr && bus_sel == 2'd0 && bus_wdata[4]) begin
        n_pend = 0; n_seen = 0; n_svc = 0; n_mask = 8'hFF; n_auto = 1;
        n_up = 0; n_fourth = bus_wdata[0]; n_step = 1;
      end
      m_pend = n_pend; m_seen = n_seen; m_svc = n_svc; m_mask = n_mask;
      m_base = n_base; m_trig = n_trig; m_auto = n_auto; m_fourth = n_fourth;
      m_rdsvc = n_rdsvc; m_smm = n_smm; m_up = n_up; m_line = n_line; m_step = n_step;
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check("R10 model int_req", {7'd0, int_req}, {7'd0, m_up});
      check("R12 model rdata", bus_rdata, m_read(bus_sel));
      if (int_ack) check("R8 model vector", ack_vector, m_vec());
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(logic [1:0] s, logic [7:0] d);
    @(posedge clk); #1;
    bus_wr = 1; bus_sel = s; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] s, logic [7:0] exp, string tag);
    @(posedge clk); #1;
    bus_sel = s;
    @(negedge clk);
    check(tag, bus_rdata, exp);
  endtask

  task automatic req_is(bit exp, string tag);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(tag, {7'd0, int_req}, {7'd0, exp});
  endtask

  task automatic ack(logic [7:0] exp, string tag);
    @(posedge clk); #1;
    int_ack = 1;
    @(negedge clk);
    check(tag, ack_vector, exp);
    @(posedge clk); #1;
    int_ack = 0;
    @(negedge clk);
    check("R10 low after ack", {7'd0, int_req}, 8'h00);
  endtask

  task automatic lines(logic [7:0] v);
    @(posedge clk); #1;
    irq_lines = v;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cmp_on = 1;
    // R1 reset state
    @(negedge clk);
    check("R1 int_req", {7'd0, int_req}, 8'h00);
    rd(2'd1, 8'hFF, "R1 mask");
    rd(2'd2, 8'h00, "R1 trig");
    rd(2'd0, 8'h00, "R1 cmd read");
    rd(2'd3, 8'h00, "R12 unused port");
    // R3 set-up with fourth word, manual end-of-interrupt
    wr(2'd0, 8'h11); wr(2'd1, 8'h20); wr(2'd1, 8'h00); wr(2'd1, 8'h01);
    rd(2'd1, 8'hFF, "R3 fourth word not mask");
    wr(2'd1, 8'h00);
    rd(2'd1, 8'h00, "R3 mask load");
    // R6 R7 R8 basic delivery
    lines(8'h08);
    req_is(1, "R7 line3 raised");
    rd(2'd0, 8'h08, "R6 pending line3");
    ack(8'h23, "R8 vector line3");
    rd(2'd0, 8'h00, "R8 edge pending cleared");
    wr(2'd0, 8'h0B);
    rd(2'd0, 8'h08, "R4 read in-service");
    // R7 nesting
    lines(8'h0A);
    req_is(1, "R7 line1 preempts");
    ack(8'h21, "R8 vector line1");
    rd(2'd0, 8'h0A, "R8 in-service set");
    lines(8'h2A);
    req_is(0, "R7 line5 blocked");
    wr(2'd0, 8'h20);
    req_is(0, "R7 still blocked by line3");
    rd(2'd0, 8'h08, "R5 lowest retired");
    wr(2'd0, 8'h63);
    req_is(1, "R7 line5 released");
    ack(8'h25, "R8 vector line5");
    // R5 odd codes
    wr(2'd0, 8'hC5);
    rd(2'd0, 8'h20, "R5 priority code no effect");
    wr(2'd0, 8'h80);
    rd(2'd0, 8'h00, "R5 other code acts as lowest");
    // R7 special mask mode
    lines(8'h2B);
    req_is(1, "R7 line0 raised");
    ack(8'h20, "R8 vector line0");
    lines(8'h2F);
    req_is(0, "R7 line2 blocked by line0");
    wr(2'd0, 8'h68);
    wr(2'd1, 8'h01);
    req_is(1, "R7 special mask releases line2");
    ack(8'h22, "R8 vector line2");
    rd(2'd0, 8'h05, "R7 in-service lines 0 and 2");
    wr(2'd0, 8'h48);
    wr(2'd0, 8'h60); wr(2'd0, 8'h62);
    wr(2'd1, 8'h00);
    rd(2'd0, 8'h00, "R5 specific retire");
    // R6 masking and deassert
    lines(8'h00);
    wr(2'd1, 8'h40);
    lines(8'h40);
    req_is(0, "R7 masked line6");
    wr(2'd0, 8'h0A);
    rd(2'd0, 8'h40, "R6 pending while masked");
    lines(8'h00);
    rd(2'd0, 8'h00, "R6 deassert clears");
    wr(2'd1, 8'h00);
    // R8 R9 level mode and spurious acknowledge
    wr(2'd2, 8'h10);
    rd(2'd2, 8'h10, "R11 trig readback");
    lines(8'h10);
    req_is(1, "R7 line4 raised");
    ack(8'h24, "R8 vector line4");
    rd(2'd0, 8'h10, "R8 level keeps pending");
    wr(2'd0, 8'h0B);
    wr(2'd0, 8'h20);
    req_is(1, "R8 level re-request");
    lines(8'h00);
    req_is(1, "R10 held with pending gone");
    ack(8'h27, "R9 spurious vector");
    rd(2'd0, 8'h00, "R9 in-service unchanged");
    // R2 R11 restart with auto end-of-interrupt
    wr(2'd0, 8'h13);
    rd(2'd1, 8'hFF, "R2 masked after start");
    rd(2'd2, 8'h10, "R11 trig survives start");
    wr(2'd1, 8'h40); wr(2'd1, 8'h00); wr(2'd1, 8'h03); wr(2'd1, 8'h00);
    lines(8'h40);
    req_is(1, "R7 line6 raised");
    ack(8'h46, "R3 new base vector");
    rd(2'd0, 8'h00, "R8 auto no in-service");
    lines(8'h00);
    // R3 start without fourth word
    wr(2'd0, 8'h10); wr(2'd1, 8'h80); wr(2'd1, 8'hFF); wr(2'd1, 8'h5A);
    rd(2'd1, 8'h5A, "R3 cascade ignored, mask loaded");
    wr(2'd1, 8'h00);
    lines(8'h02);
    req_is(1, "R7 line1 raised");
    ack(8'h81, "R3 base 0x80");
    // R2 withdraw a raised request
    lines(8'h82);
    req_is(1, "R7 line7 raised");
    wr(2'd0, 8'h10);
    @(negedge clk);
    check("R2 request withdrawn", {7'd0, int_req}, 8'h00);
    rd(2'd1, 8'hFF, "R2 all masked");
    wr(2'd1, 8'h00); wr(2'd1, 8'h00);
    lines(8'h00);
    repeat (2) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule